// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. It is built from a configurable number of 8-pin ports that share one register window. Every port owns an identical group of registers, and each group starts a fixed 0x30 bytes after the previous one. Through these registers software can:

- read the synchronized pad levels;
- set output data and a per-pin drive style;
- switch pull-ups on and off;
- choose, per pin, whether the rising or the falling edge raises an event.

Events latch in a per-port register and are cleared by writing ones. A per-port mask gates them onto one active-high interrupt line per port. A test register lets software force events.

The pads are presented as four separate vectors: sampled input, output value, output enable and pull-up enable. The pad cells themselves are outside the block. Word 0x00 of the window is a global control word. It reports the number of ports and a version number, and it holds two writable enable bits. The register bus is single-cycle: writes take effect on the clock edge, and read data is valid in the same cycle the address is presented.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every pad output enable is 0, every interrupt output is 0, every event, enable, force and edge-select bit is 0, and every pull-up is enabled.
- R2: The word at address 0x00 reads the port count in bits [15:9] and the version number in bits [8:2]. Bits [1:0] are writable and read back; writes to the other bits have no effect.
- R3: The register at port offset 0x04 returns the pad levels of the port's 8 pins. A pad change is visible in this register after two rising clock edges, and not after one.
- R4: The drive register at offset 0x0C holds 2 bits per pin at bits [2i+1:2i], and the output data register is at offset 0x08. The drive codes are:
  - 00: input, with output enable low.
  - 01: push-pull, with output enable high and the pad driven to the data bit.
  - 10: sink-only, which enables the pad only while the data bit is 0 and then drives 0.
  - 11: source-only, which enables the pad only while the data bit is 1 and then drives 1.
- R5: In the pull-up register at offset 0x10, bit i set to 1 turns the pin's pull-up off. Bit i set to 0 turns it on.
- R6: In the edge-select register at offset 0x20, bit value 1 picks the rising edge and bit value 0 picks the falling edge. An edge in the other direction sets no event.
- R7: The event register at offset 0x14 records the selected edge even while the pin's interrupt enable is 0. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R8: Each port's interrupt output is a registered OR of (event AND enable) over its pins, with the enable register at offset 0x18. A port's output does not react to another port's events.
- R9: While a bit of the force register at offset 0x1C is 1, the matching event bit is held at 1 and a write-1 clear has no effect. After the force bit is written to 0, the event stays set until it is cleared.
- R10: A read returns 0, and a write changes nothing, for any of these addresses:
  - a port index at or beyond the port count;
  - offsets 0x24 to 0x2C of any port;
  - offset 0x00 of any port other than port 0;
  - an address that is not word aligned.
- R11: The registers of port p are at p*0x30 plus the offset, and a write to one port leaves the other ports' registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |
| pad_in | input | 8*NUM_PORTS | Pad levels, pin 8p+i is port p pin i |
| pad_out | output | 8*NUM_PORTS | Pad drive value |
| pad_oe | output | 8*NUM_PORTS | Pad output enable |
| pad_pu_en | output | 8*NUM_PORTS | Pad pull-up enable |
| irq | output | NUM_PORTS | Per-port interrupt, active high |

## Verification
The bench first samples the input register one edge and two edges after a pad change. A design that skipped or added a synchronizer stage would show the new value at the wrong time. It then drives edges in the direction opposite to the selected one. A swapped edge-select sense would latch events on exactly those edges.

Events are raised while the enable is 0, so a design that gated capture with the enable would lose them. The bench then writes 0 and 1 to an event bit, which catches a design that clears on zero or on any write. It also writes a clear while the force bit is high and after the force bit is released, which separates a held event from one that is only pulsed.

In the sink-only and source-only modes the enable depends on the data bit, and a decode error shows up as a pad driven against its level. The bench also accesses port indices beyond the port count, reserved offsets, offset 0x00 of a later port and misaligned addresses. A design with a loose decoder would alias these onto live registers.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int MAX_PORTS     = 7;
  localparam int PORT_STRIDE   = 48;

  localparam logic [5:0] OFF_CTRL  = 6'h00;
  localparam logic [5:0] OFF_IN    = 6'h04;
  localparam logic [5:0] OFF_OUT   = 6'h08;
  localparam logic [5:0] OFF_DRIVE = 6'h0C;
  localparam logic [5:0] OFF_PULL  = 6'h10;
  localparam logic [5:0] OFF_EVENT = 6'h14;
  localparam logic [5:0] OFF_MASK  = 6'h18;
  localparam logic [5:0] OFF_FORCE = 6'h1C;
  localparam logic [5:0] OFF_EDGE  = 6'h20;

  typedef enum logic [1:0] {
    DRV_INPUT  = 2'b00,
    DRV_PUSH   = 2'b01,
    DRV_SINK   = 2'b10,
    DRV_SOURCE = 2'b11
  } drive_e;

  typedef struct packed {
    logic       hit;
    logic       glob;
    logic [2:0] port;
    logic [5:0] off;
  } dec_t;

  // returns {oe, out}
  function automatic logic [1:0] pad_drive(input logic [1:0] mode, input logic d);
    case (drive_e'(mode))
      DRV_PUSH:   return {1'b1, d};
      DRV_SINK:   return {~d, 1'b0};
      DRV_SOURCE: return {d, 1'b1};
      default:    return 2'b00;
    endcase
  endfunction

  function automatic logic [PINS_PER_PORT-1:0] edge_hits(
      input logic [PINS_PER_PORT-1:0] cur,
      input logic [PINS_PER_PORT-1:0] prev,
      input logic [PINS_PER_PORT-1:0] rising);
    return (rising & cur & ~prev) | (~rising & ~cur & prev);
  endfunction

  function automatic dec_t decode(input logic [15:0] a, input int nports);
    dec_t d;
    logic found;
    d = '0;
    found = 1'b0;
    for (int p = 0; p < MAX_PORTS; p++) begin
      if (int'(a) >= p * PORT_STRIDE && int'(a) < (p + 1) * PORT_STRIDE) begin
        found  = 1'b1;
        d.port = 3'(p);
        d.off  = 6'(int'(a) - p * PORT_STRIDE);
      end
    end
    if (found && a[1:0] == 2'b00 && int'(d.port) < nports) begin
      if (d.off == OFF_CTRL) begin
        d.glob = (d.port == 3'd0);
        d.hit  = d.glob;
      end else if (d.off >= OFF_IN && d.off <= OFF_EDGE) begin
        d.hit = 1'b1;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpb_port.sv
module gpb_port
  import gpb_pkg::*;
#(
  parameter int PINS = PINS_PER_PORT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [5:0]      off,
  input  logic [31:0]     wdata,
  output logic [31:0]     rd_data,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_pu_en,
  output logic            irq,
  output logic [PINS-1:0] ev_o,
  output logic [PINS-1:0] en_o,
  output logic [PINS-1:0] hit_o,
  output logic [PINS-1:0] frc_o,
  output logic [PINS-1:0] clr_o,
  output logic [2*PINS-1:0] mode_o
);
  localparam int MODE_W = 2 * PINS;

  logic [PINS-1:0]   sync_q, prev_q, out_q, pull_q, ev_q, en_q, frc_q, edge_q;
  logic [MODE_W-1:0] mode_q;
  logic [PINS-1:0]   hit, clr;
  logic              irq_q;

  gpb_sync #(.W(PINS)) u_sync (.clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q));

  assign hit = edge_hits(sync_q, prev_q, edge_q);
  assign clr = (wr_en && off == OFF_EVENT) ? wdata[PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      out_q  <= '0;
      mode_q <= '0;
      pull_q <= '0;
      ev_q   <= '0;
      en_q   <= '0;
      frc_q  <= '0;
      edge_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= sync_q;
      ev_q   <= (ev_q & ~clr) | hit | frc_q;
      irq_q  <= |(ev_q & en_q);
      if (wr_en) begin
        case (off)
          OFF_OUT:   out_q  <= wdata[PINS-1:0];
          OFF_DRIVE: mode_q <= wdata[MODE_W-1:0];
          OFF_PULL:  pull_q <= wdata[PINS-1:0];
          OFF_MASK:  en_q   <= wdata[PINS-1:0];
          OFF_FORCE: frc_q  <= wdata[PINS-1:0];
          OFF_EDGE:  edge_q <= wdata[PINS-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] drv;
    assign drv          = pad_drive(mode_q[2*i +: 2], out_q[i]);
    assign pad_oe[i]    = drv[1];
    assign pad_out[i]   = drv[0];
    assign pad_pu_en[i] = ~pull_q[i];
  end

  always_comb begin
    rd_data = '0;
    case (off)
      OFF_IN:    rd_data[PINS-1:0]   = sync_q;
      OFF_OUT:   rd_data[PINS-1:0]   = out_q;
      OFF_DRIVE: rd_data[MODE_W-1:0] = mode_q;
      OFF_PULL:  rd_data[PINS-1:0]   = pull_q;
      OFF_EVENT: rd_data[PINS-1:0]   = ev_q;
      OFF_MASK:  rd_data[PINS-1:0]   = en_q;
      OFF_FORCE: rd_data[PINS-1:0]   = frc_q;
      OFF_EDGE:  rd_data[PINS-1:0]   = edge_q;
      default: ;
    endcase
  end

  assign irq    = irq_q;
  assign ev_o   = ev_q;
  assign en_o   = en_q;
  assign hit_o  = hit;
  assign frc_o  = frc_q;
  assign clr_o  = clr;
  assign mode_o = mode_q;
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpb_pkg::*;
#(
  parameter int          NUM_PORTS  = 3,
  parameter int          ADDR_W     = 10,
  parameter logic [6:0]  VERSION_ID = 7'h11
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_sel,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_in,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_out,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_oe,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_pu_en,
  output logic [NUM_PORTS-1:0]           irq
);
  localparam int NPINS = NUM_PORTS * PINS_PER_PORT;
  localparam logic [6:0] PORT_COUNT = 7'(NUM_PORTS);

  dec_t              dec;
  logic [1:0]        ctrl_q;
  logic [31:0]       port_rd [NUM_PORTS];
  logic [NPINS-1:0]  ev_all, en_all, hit_all, frc_all, clr_all;
  logic [2*NPINS-1:0] mode_all;

  assign dec = decode(16'(bus_addr), NUM_PORTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (bus_sel && bus_we && dec.hit && dec.glob) ctrl_q <= bus_wdata[1:0];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_en;
    assign wr_en = bus_sel && bus_we && dec.hit && !dec.glob && (int'(dec.port) == p);
    gpb_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .off      (dec.off),
      .wdata    (bus_wdata),
      .rd_data  (port_rd[p]),
      .pad_in   (pad_in[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .pad_out  (pad_out[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .pad_oe   (pad_oe[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .pad_pu_en(pad_pu_en[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .irq      (irq[p]),
      .ev_o     (ev_all[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .en_o     (en_all[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .hit_o    (hit_all[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .frc_o    (frc_all[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .clr_o    (clr_all[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .mode_o   (mode_all[2*p*PINS_PER_PORT +: 2*PINS_PER_PORT])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && dec.hit) begin
      if (dec.glob) begin
        bus_rdata[15:9] = PORT_COUNT;
        bus_rdata[8:2]  = VERSION_ID;
        bus_rdata[1:0]  = ctrl_q;
      end else begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (int'(dec.port) == p) bus_rdata = port_rd[p];
      end
    end
  end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_sel,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_rdata,
  input logic [NUM_PORTS-1:0]      irq,
  input logic [NUM_PORTS*8-1:0]    pad_oe,
  input logic [NUM_PORTS*8-1:0]    pad_out,
  input logic [NUM_PORTS*8-1:0]    ev_all,
  input logic [NUM_PORTS*8-1:0]    en_all,
  input logic [NUM_PORTS*8-1:0]    hit_all,
  input logic [NUM_PORTS*8-1:0]    frc_all,
  input logic [NUM_PORTS*8-1:0]    clr_all,
  input logic [NUM_PORTS*16-1:0]   mode_all
);
  localparam int NPINS = NUM_PORTS * 8;
  localparam int WINDOW = NUM_PORTS * 48;

  // R10: reads past the last port window return zero
  p_beyond_ports_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && int'(bus_addr) >= WINDOW) |-> (bus_rdata == 32'd0));

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    // R7: a selected edge always latches an event
    p_edge_latches_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_all[g] |=> ev_all[g]);
    // R7: a clear with no new edge and no force empties the bit
    p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all[g] && !hit_all[g] && !frc_all[g]) |=> !ev_all[g]);
    // R9: force holds the event set
    p_force_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frc_all[g] |=> ev_all[g]);
    // R4: input mode never enables the pad
    p_input_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_all[2*g +: 2] == 2'b00) |-> !pad_oe[g]);
    // R4: sink-only never drives high
    p_sink_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_all[2*g +: 2] == 2'b10 && pad_oe[g]) |-> !pad_out[g]);
    // R4: source-only never drives low
    p_source_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_all[2*g +: 2] == 2'b11 && pad_oe[g]) |-> pad_out[g]);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    // R8: no enabled event means the line is low one cycle later
    p_irq_needs_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_all[p*8 +: 8] & en_all[p*8 +: 8]) == 8'd0) |=> !irq[p]);
    // R8: an enabled event raises the line one cycle later
    p_irq_raised_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_all[p*8 +: 8] & en_all[p*8 +: 8]) != 8'd0) |=> irq[p]);
  end
endmodule

bind gpio_port_bank gpb_checker #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .pad_oe   (pad_oe),
  .pad_out  (pad_out),
  .ev_all   (ev_all),
  .en_all   (en_all),
  .hit_all  (hit_all),
  .frc_all  (frc_all),
  .clr_all  (clr_all),
  .mode_all (mode_all)
);

// File: tb/sim_gpio_port_bank.sv
module sim_gpio_port_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int AW = 10;
  localparam logic [6:0] VER = 7'h11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP*8-1:0] pad_in = '0;
  logic [NP*8-1:0] pad_out, pad_oe, pad_pu_en;
  logic [NP-1:0]   irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  gpio_port_bank #(.NUM_PORTS(NP), .ADDR_W(AW), .VERSION_ID(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu_en(pad_pu_en), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int reg_addr(int port, int off);
    return port * 48 + off;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 oe", 32'(pad_oe), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 pullup", 32'(pad_pu_en), 32'hFF_FFFF);
    rd(reg_addr(1, 16'h14), v); chk("R1 event", v, 32'd0);
    rd(reg_addr(2, 16'h20), v); chk("R1 edge", v, 32'd0);
  endtask

  task automatic t_global;
    logic [31:0] v;
    rd(0, v); chk("R2 ident", v, (32'(NP) << 9) | (32'(VER) << 2));
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R2 ctrl bits", v, (32'(NP) << 9) | (32'(VER) << 2) | 32'd3);
    wr(0, 32'd1);
    rd(0, v); chk("R2 ctrl one", v, (32'(NP) << 9) | (32'(VER) << 2) | 32'd1);
  endtask

  task automatic t_input_and_edges;
    logic [31:0] v;
    pad_in[15:8] = 8'hA5;
    rd(reg_addr(1, 4), v); chk("R3 after one edge", v, 32'd0);
    rd(reg_addr(1, 4), v); chk("R3 after two edges", v, 32'hA5);
    ticks(3);
    rd(reg_addr(1, 16'h14), v); chk("R6 rising ignored under falling select", v, 32'd0);
    pad_in[15:8] = 8'h00;
    ticks(4);
    rd(reg_addr(1, 16'h14), v); chk("R6 falling latched", v, 32'hA5);
    wr(reg_addr(1, 16'h14), 32'hFF);
    rd(reg_addr(1, 16'h14), v); chk("R7 clear port1", v, 32'd0);
  endtask

  task automatic t_drive;
    logic [31:0] v;
    wr(reg_addr(0, 16'h0C), 32'h00E4);
    wr(reg_addr(0, 8), 32'h0F);
    chk("R4 oe data1", 32'(pad_oe[3:0]), 32'b1010);
    chk("R4 out data1", 32'(pad_out[3:0] & pad_oe[3:0]), 32'b1010);
    wr(reg_addr(0, 8), 32'h00);
    chk("R4 oe data0", 32'(pad_oe[3:0]), 32'b0110);
    chk("R4 out data0", 32'(pad_out[3:0] & pad_oe[3:0]), 32'b0000);
    rd(reg_addr(0, 16'h0C), v); chk("R4 drive readback", v, 32'h00E4);
  endtask

  task automatic t_pull;
    wr(reg_addr(2, 16'h10), 32'h0F);
    chk("R5 pullup port2", 32'(pad_pu_en[23:16]), 32'hF0);
    chk("R5 other ports", 32'(pad_pu_en[15:0]), 32'hFFFF);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(reg_addr(2, 16'h20), 32'h01);
    pad_in[16] = 1'b1;
    ticks(4);
    rd(reg_addr(2, 16'h14), v); chk("R7 event without enable", v, 32'h01);
    chk("R8 masked irq low", 32'(irq), 32'd0);
    wr(reg_addr(2, 16'h18), 32'h01);
    ticks(1);
    chk("R8 irq port2 only", 32'(irq), 32'b100);
    wr(reg_addr(2, 16'h14), 32'h00);
    rd(reg_addr(2, 16'h14), v); chk("R7 write zero keeps", v, 32'h01);
    wr(reg_addr(2, 16'h14), 32'h01);
    ticks(1);
    chk("R8 irq drops", 32'(irq), 32'd0);
    rd(reg_addr(2, 16'h14), v); chk("R7 write one clears", v, 32'd0);
  endtask

  task automatic t_force;
    logic [31:0] v;
    wr(reg_addr(0, 16'h1C), 32'h80);
    ticks(1);
    rd(reg_addr(0, 16'h14), v); chk("R9 forced set", v, 32'h80);
    wr(reg_addr(0, 16'h14), 32'h80);
    rd(reg_addr(0, 16'h14), v); chk("R9 clear blocked", v, 32'h80);
    wr(reg_addr(0, 16'h1C), 32'h00);
    rd(reg_addr(0, 16'h14), v); chk("R9 held after release", v, 32'h80);
    wr(reg_addr(0, 16'h14), 32'h80);
    rd(reg_addr(0, 16'h14), v); chk("R9 clear after release", v, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    logic [NP*8-1:0] oe_before;
    rd(reg_addr(3, 4), v);  chk("R10 port beyond count", v, 32'd0);
    rd(reg_addr(0, 16'h24), v); chk("R10 reserved offset", v, 32'd0);
    rd(reg_addr(0, 16'h0D), v); chk("R10 misaligned", v, 32'd0);
    rd(reg_addr(1, 0), v);  chk("R10 port1 offset0", v, 32'd0);
    oe_before = pad_oe;
    wr(reg_addr(3, 8), 32'hFF);
    wr(reg_addr(0, 16'h24), 32'hFF);
    wr(reg_addr(0, 16'h09), 32'hFF);
    wr(reg_addr(1, 0), 32'h3);
    rd(reg_addr(0, 8), v); chk("R10 out data untouched", v, 32'd0);
    chk("R10 pads untouched", 32'(pad_oe), 32'(oe_before));
    rd(0, v); chk("R10 ctrl untouched", v, (32'(NP) << 9) | (32'(VER) << 2) | 32'd1);
  endtask

  task automatic t_stride;
    logic [31:0] v;
    wr(reg_addr(1, 8), 32'h5A);
    rd(reg_addr(1, 8), v); chk("R11 port1 out", v, 32'h5A);
    rd(reg_addr(0, 8), v); chk("R11 port0 unchanged", v, 32'd0);
    rd(reg_addr(2, 8), v); chk("R11 port2 unchanged", v, 32'd0);
  endtask

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
    t_reset();
    t_global();
    t_input_and_edges();
    t_drive();
    t_pull();
    t_irq();
    t_force();
    t_unmapped();
    t_stride();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule